// File: doc/BRIEF.md
# Mixed-Ratio Reference Prescaler Chain

This block takes one fast reference clock and derives five slower rates from it as clock-enable taps. No derived clocks are produced. The chain is built from three counter stages. A halving stage runs on every enabled reference cycle. A fast pair of counters, one modulo 2 and one modulo 5, advances on each rollover of the halving stage. A slow pair, one modulo 2 and one modulo 4, advances on each rollover of the modulo-5 counter. With a 20.48 MHz reference the taps therefore sit at 10.24 MHz, 5.12 MHz, 2.048 MHz, 1.024 MHz and 512 kHz. The ratios do not form a plain binary ladder, because the modulo-5 stage in the middle drives the slow pair.

Each tap is available in two forms. The first is a one-reference-cycle pulse that coincides with the cycle in which its counter rolls over. The second is a square wave that is high for the first half (rounded down) of its counter's states. A run enable freezes every counter and silences every pulse. The surrounding logic drops this enable when it switches to an external clock source. A synchronous active-high reset returns all counters to state zero, so every tap starts from a known phase.

Top module: `presc_chain`

## Requirements
- R1: After a synchronous reset with `run_en` high, no pulse appears in `tick_o` and every bit of `wave_o` is 1. All counters are at state zero.
- R2: `tick_o[0]` pulses on every 2nd enabled reference cycle. Counting enabled cycles from reset as k = 0, 1, 2, …, the pulse appears when k mod 2 = 1.
- R3: `tick_o[1]` pulses when k mod 4 = 3.
- R4: `tick_o[2]` pulses when k mod 10 = 9. Its counter passes through states 0 to 4 and then wraps to 0.
- R5: `tick_o[3]` pulses when k mod 20 = 19.
- R6: `tick_o[4]` pulses when k mod 40 = 39.
- R7: In any cycle where `run_en` is 0, all of `tick_o` is 0, no counter changes, and `wave_o` keeps its value.
- R8: Each `wave_o[i]` is high while its counter is in the lower floor(M/2) states. For the tap periods 2, 4, 10, 20 and 40 this means `wave_o[i]` is 1 when k mod P < 1, 2, 4, 10 and 20 respectively. The divide-by-10 tap is therefore high for 4 cycles and low for 6.
- R9: Pulses on the second and third stages nest inside the pulses that advance them. A pulse on `tick_o[1]` or `tick_o[2]` comes with a pulse on `tick_o[0]`. A pulse on `tick_o[3]` or `tick_o[4]` comes with a pulse on `tick_o[2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Counting enable; low freezes the chain |
| tick_o | output | 5 | One-cycle rollover pulses for divide by 2, 4, 10, 20, 40 (bits 0 to 4) |
| wave_o | output | 5 | Square-wave form of the same five taps |

## Verification
A counter in the wrong state shows up at the ports within one period of its tap. Either a pulse arrives at the wrong k, or a square wave changes level at the wrong point. The bench sweeps every phase of the longest period, 40 cycles, several times. It does this under steady enable, under an irregular enable pattern and across a mid-run reset, and compares all ten outputs every cycle against the k mod P formulas. If the modulo-5 stage miscounts or the stage feeding the slow pair is wrong, the divide-by-10 tap is off within 10 enabled cycles and the slow taps are off within 40.

// File: rtl/presc_pkg.sv
package presc_pkg;
    localparam int NUM_TAPS = 5;

    // Stage moduli: halving stage, fast pair, slow pair
    localparam int HALF_MOD   = 2;
    localparam int FAST_LO_MOD = 2;
    localparam int FAST_HI_MOD = 5;
    localparam int SLOW_LO_MOD = 2;
    localparam int SLOW_HI_MOD = 4;

    typedef struct packed {
        logic tick;
        logic wave;
    } tap_t;

    function automatic int cnt_width(input int m);
        return (m <= 2) ? 1 : $clog2(m);
    endfunction
endpackage

// File: rtl/presc_modn.sv
module presc_modn
    import presc_pkg::*;
#(
    parameter int MOD = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output tap_t tap
);
    localparam int W = cnt_width(MOD);
    localparam logic [W-1:0] LAST = W'(MOD - 1);
    localparam logic [W-1:0] HALF = W'(MOD / 2);

    logic [W-1:0] cnt;
    logic         at_last;

    assign at_last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (adv)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    assign tap.tick = adv & at_last;
    assign tap.wave = (cnt < HALF);

    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);
    // R7
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt));
    // R4
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        tap.tick |=> (cnt == '0));
    // R1
    cnt_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cnt == '0));
endmodule

// File: rtl/presc_pair.sv
module presc_pair
    import presc_pkg::*;
#(
    parameter int MOD_LO = 2,
    parameter int MOD_HI = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     adv,
    output tap_t [1:0] taps
);
    for (genvar g = 0; g < 2; g++) begin : g_sec
        localparam int M = (g == 0) ? MOD_LO : MOD_HI;
        presc_modn #(.MOD(M)) u_cnt (
            .clk (clk),
            .rst (rst),
            .adv (adv),
            .tap (taps[g])
        );
    end

    // R9
    pair_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (taps[0].tick | taps[1].tick) |-> adv);
endmodule

// File: rtl/presc_chain.sv
module presc_chain
    import presc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                run_en,
    output logic [NUM_TAPS-1:0] tick_o,
    output logic [NUM_TAPS-1:0] wave_o
);
    tap_t       half_tap;
    tap_t [1:0] fast_taps;
    tap_t [1:0] slow_taps;
    tap_t [NUM_TAPS-1:0] all_taps;

    presc_modn #(.MOD(HALF_MOD)) u_half (
        .clk (clk),
        .rst (rst),
        .adv (run_en),
        .tap (half_tap)
    );

    presc_pair #(.MOD_LO(FAST_LO_MOD), .MOD_HI(FAST_HI_MOD)) u_fast (
        .clk  (clk),
        .rst  (rst),
        .adv  (half_tap.tick),
        .taps (fast_taps)
    );

    // slow pair is advanced by the modulo-5 rollover
    presc_pair #(.MOD_LO(SLOW_LO_MOD), .MOD_HI(SLOW_HI_MOD)) u_slow (
        .clk  (clk),
        .rst  (rst),
        .adv  (fast_taps[1].tick),
        .taps (slow_taps)
    );

    assign all_taps = {slow_taps[1], slow_taps[0], fast_taps[1], fast_taps[0], half_tap};

    for (genvar i = 0; i < NUM_TAPS; i++) begin : g_out
        assign tick_o[i] = all_taps[i].tick;
        assign wave_o[i] = all_taps[i].wave;
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |-> (tick_o == '0));
    // R7
    idle_wave_chk: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> $stable(wave_o));
    // R9
    slow_nest_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o[3] | tick_o[4]) |-> tick_o[2]);
    // R2
    half_alt_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o[0] |=> !tick_o[0]);
endmodule

// File: tb/tb_presc_chain.sv
module tb_presc_chain;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       run_en = 1'b0;
    logic [4:0] tick_o, wave_o;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit done = 1'b0;

    // input-period and modulus of each tap's stage
    int sub_p [5] = '{1, 2, 2, 10, 10};
    int mod_p [5] = '{2, 2, 5, 2, 4};

    presc_chain dut (
        .clk    (clk),
        .rst    (rst),
        .run_en (run_en),
        .tick_o (tick_o),
        .wave_o (wave_o)
    );

    always #2.5 clk = ~clk;

    function automatic string tick_tag(input int i);
        case (i)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_bit(input string tag, input int idx, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tap %0d k=%0d: actual %b expected %b", tag, idx, k, act, exp);
        end
    endtask

    // drive at negedge, compare 1 ns later, then advance the model
    task automatic step(input logic en, input logic rs);
        @(negedge clk);
        run_en = en;
        rst = rs;
        #1;
        for (int i = 0; i < 5; i++) begin
            int p = sub_p[i] * mod_p[i];
            int h = sub_p[i] * (mod_p[i] / 2);
            logic et = en && ((k % p) == p - 1);
            logic ew = ((k % p) < h);
            check_bit(en ? tick_tag(i) : "R7", i, tick_o[i], et);
            check_bit("R8", i, wave_o[i], ew);
        end
        // R9 nesting
        checks++;
        if (((tick_o[1] | tick_o[2]) && !tick_o[0]) || ((tick_o[3] | tick_o[4]) && !tick_o[2])) begin
            errors++;
            $display("FAIL R9 k=%0d: actual ticks %b expected nested", k, tick_o);
        end
        if (rs) k = 0;
        else if (en) k++;
    endtask

    initial begin
        logic [7:0] lfsr = 8'hA5;
        repeat (3) begin
            @(negedge clk);
            rst = 1'b1;
            run_en = 1'b1;
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        checks++;
        if (tick_o !== 5'b0 || wave_o !== 5'b11111) begin
            errors++;
            $display("FAIL R1: actual tick %b wave %b expected 00000 11111", tick_o, wave_o);
        end
        @(posedge clk);
        k = 1;
        // steady run over several longest periods
        for (int c = 0; c < 199; c++) step(1'b1, 1'b0);
        // irregular enable
        for (int c = 0; c < 400; c++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0] | lfsr[2], 1'b0);
        end
        // long idle stretch, R7
        for (int c = 0; c < 60; c++) step(1'b0, 1'b0);
        // mid-run reset then resume
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        for (int c = 0; c < 120; c++) step(1'b1, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule